// File: doc/BRIEF.md
# Page-Aware SPI Register Proxy

This block sits between an SPI host and a downstream sensor that uses 16-bit register words. It has a slave port facing the host and a master port facing the sensor. Each host word carries a direction flag and a register address in its upper byte, and write data in its lower byte. The block keeps its own copy of the active register page. While a sensor page is selected, it forwards host traffic to the sensor. While one of the three local buffer pages (253, 254, 255) is selected, it answers locally and the sensor port stays quiet.

A forwarded read turns into two sensor transactions. The first carries the request and the second, an all-zero word, clocks the register value back. That value is staged and shifted out to the host during the host's next word. A forwarded write is sent once, and whatever the sensor returns during that single transaction is staged in the same way. A busy flag covers the whole sequence. Host words that arrive while it is high are dropped and counted in a saturating overrun counter. Both ports use SPI mode 3 (clock idles high, data launched on the falling edge and sampled on the rising edge, MSB first) with an active-low select. The sensor clock half period is set by a parameter.

Top module: `spi_bridge`

## Requirements
- R1: A host word is 16 bits, MSB first. Bit 15 = 1 marks a write and bit 15 = 0 marks a read. Bits 14:8 hold the address and bits 7:0 the write data. A forwarded word is sent to the sensor unchanged as the first master word.
- R2: A forwarded read produces exactly two sensor transactions: the host word, then 16'h0000.
- R3: The word that the sensor returns in the second transaction of a forwarded read is shifted out to the host during the host's next word.
- R4: A forwarded write produces exactly one sensor transaction. The word the sensor returns in that transaction is shifted out to the host during the host's next word.
- R5: While the page is 253, 254 or 255, no sensor transaction occurs. A local read of address 0 stages 16'h00PP, where PP is the current page. Any other local word stages 16'h0000.
- R6: A write to address 0 sets the page tracker to bits 7:0, whatever the current page is. It is forwarded only if the new page is below 253. Words other than page writes are forwarded exactly when the current page is below 253.
- R7: Busy rises once a host word is captured and falls when its sequence ends. A host word captured while busy is high is dropped and raises the overrun count by one, saturating at all ones.
- R8: On both ports the clock is high whenever chip select is high, and chip select only changes while the clock is high.
- R9: Every sensor clock phase lasts CLK_DIV clock cycles. This includes the high phase between chip select falling and the first falling clock edge, and the high phase before chip select rises. Between back-to-back transactions, chip select stays high for at least CS_GAP cycles.
- R10: If host chip select rises before 16 bits have arrived, the partial word is discarded. It causes no sensor traffic, no busy pulse, no overrun count and no change to the staged word.
- R11: After reset the page is 0, busy is low, the overrun count is 0, the staged word is 16'h0000, and the sensor port is idle (select high, clock high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSclk | input | 1 | Host SPI clock, mode 3 |
| hostCsN | input | 1 | Host chip select, active low |
| hostMosi | input | 1 | Host data into the block |
| hostMiso | output | 1 | Staged response data to the host |
| sensSclk | output | 1 | Sensor SPI clock, idles high |
| sensCsN | output | 1 | Sensor chip select, active low |
| sensMosi | output | 1 | Data to the sensor |
| sensMiso | input | 1 | Data from the sensor |
| busy | output | 1 | High while a captured host word is being processed |
| overrunCount | output | OVR_W | Saturating count of dropped host words |

## Verification
The hardest state to reach from the ports is a host word that lands while a forwarded read is still busy on the sensor side. The stimulus creates it by starting a second host word immediately after a read, with no wait on busy. The sensor transaction pair is longer than one host word, so the second word is captured mid-sequence. The bench then checks that the overrun count moved by one, that the dropped write never reached the sensor, and that the read's data still comes back on the next word. A behavioural sensor model answers each transaction from its own page and register rules, which lets the bench predict every staged response.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = WORD_W - BYTE_W - 1;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  // first page number that belongs to the local buffer range
  localparam logic [BYTE_W-1:0] LOCAL_PAGE_MIN = 8'd253;

  typedef struct packed {
    logic latchCmd;     // take the freshly captured host word
    logic setPage;      // load page tracker from command data
    logic startMaster;  // launch one sensor transaction
    logic sendDummy;    // launched transaction carries all zeros
    logic stageMaster;  // staged response <= sensor return word
    logic stageLocal;   // staged response <= locally formed word
    logic incOverrun;   // host word dropped while busy
  } bridgeStrobes_t;

  typedef enum logic [1:0] {
    C_IDLE,
    C_DISPATCH,
    C_XFER1,
    C_XFER2
  } ctrlState_t;

  typedef enum logic [2:0] {
    M_IDLE,
    M_LEAD,
    M_LOW,
    M_HIGH,
    M_GAP
  } mstState_t;

endpackage

// File: rtl/spi_bridge_datapath.sv
module spi_bridge_datapath
  import spi_bridge_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 4,
  parameter int OVR_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostSclk,
  input  logic                 hostCsN,
  input  logic                 hostMosi,
  output logic                 hostMiso,
  output logic                 sensSclk,
  output logic                 sensCsN,
  output logic                 sensMosi,
  input  logic                 sensMiso,
  input  bridgeStrobes_t       strb,
  output logic                 hostWordValid,
  output logic                 cmdIsWrite,
  output logic [ADDR_W-1:0]    cmdAddr,
  output logic [BYTE_W-1:0]    cmdData,
  output logic [BYTE_W-1:0]    page,
  output logic                 masterDone,
  output logic                 masterIdle,
  output logic [OVR_W-1:0]     overrunCount
);

  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam int NSYNC = 3;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
  localparam logic [CNT_W-1:0] BITS_ALL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] BITS_PRE = CNT_W'(WORD_W - 1);

  // ---------------- host side: synchronisers ----------------
  logic [NSYNC-1:0] rawIn;
  logic [NSYNC-1:0] syncOut;
  localparam logic [NSYNC-1:0] SYNC_RST = 3'b110; // sclk, cs idle high

  assign rawIn = {hostSclk, hostCsN, hostMosi};

  for (genvar gi = 0; gi < NSYNC; gi++) begin : g_sync
    logic [1:0] stage;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage <= {2{SYNC_RST[gi]}};
      else       stage <= {stage[0], rawIn[gi]};
    end
    assign syncOut[gi] = stage[1];
  end

  logic sclkS, csS, mosiS;
  logic sclkPrev, csPrev;
  assign {sclkS, csS, mosiS} = syncOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b1;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csS;
    end
  end

  logic sclkRise, csFall;
  assign sclkRise = sclkS & ~sclkPrev;
  assign csFall   = ~csS & csPrev;

  // ---------------- host side: shifter ----------------
  logic [CNT_W-1:0]  rxCnt;
  logic [WORD_W-1:0] rxShift;
  logic [WORD_W-1:0] hostWord;
  logic [WORD_W-1:0] txWord;
  logic [WORD_W-1:0] staged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCnt         <= '0;
      rxShift       <= '0;
      hostWord      <= '0;
      hostWordValid <= 1'b0;
      txWord        <= '0;
    end else begin
      hostWordValid <= 1'b0;
      if (csS) begin
        rxCnt <= '0;
      end else if (csFall) begin
        rxCnt  <= '0;
        txWord <= staged;
      end else if (sclkRise && rxCnt != BITS_ALL) begin
        rxShift <= {rxShift[WORD_W-2:0], mosiS};
        rxCnt   <= rxCnt + 1'b1;
        if (rxCnt == BITS_PRE) begin
          hostWord      <= {rxShift[WORD_W-2:0], mosiS};
          hostWordValid <= 1'b1;
        end
      end
    end
  end

  // bit (WORD_W-1-rxCnt) is on the line until the next rising edge
  assign hostMiso = (rxCnt == BITS_ALL) ? 1'b0 : txWord[~rxCnt[CNT_W-2:0]];

  // ---------------- command latch and page tracker ----------------
  logic [WORD_W-1:0] cmdWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cmdWord <= '0;
    else if (strb.latchCmd) cmdWord <= hostWord;
  end

  assign cmdIsWrite = cmdWord[WORD_W-1];
  assign cmdAddr    = cmdWord[WORD_W-2:BYTE_W];
  assign cmdData    = cmdWord[BYTE_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             page <= '0;
    else if (strb.setPage) page <= cmdData;
  end

  // ---------------- sensor side: master engine ----------------
  mstState_t         mState;
  logic [DIV_W-1:0]  divCnt;
  logic [GAP_W-1:0]  gapCnt;
  logic [CNT_W-1:0]  mBits;
  logic [WORD_W-1:0] mShift;
  logic [WORD_W-1:0] mRx;
  logic              halfDone;

  assign halfDone   = (divCnt == DIV_LAST);
  assign masterIdle = (mState == M_IDLE);
  assign sensMosi   = mShift[WORD_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState     <= M_IDLE;
      divCnt     <= '0;
      gapCnt     <= '0;
      mBits      <= '0;
      mShift     <= '0;
      mRx        <= '0;
      sensSclk   <= 1'b1;
      sensCsN    <= 1'b1;
      masterDone <= 1'b0;
    end else begin
      masterDone <= 1'b0;
      divCnt     <= halfDone ? '0 : divCnt + 1'b1;
      unique case (mState)
        M_IDLE: begin
          divCnt <= '0;
          if (strb.startMaster) begin
            mShift  <= strb.sendDummy ? '0 : cmdWord;
            mBits   <= '0;
            sensCsN <= 1'b0;
            mState  <= M_LEAD;
          end
        end
        M_LEAD: begin
          if (halfDone) begin
            sensSclk <= 1'b0;
            mState   <= M_LOW;
          end
        end
        M_LOW: begin
          if (halfDone) begin
            sensSclk <= 1'b1;
            mRx      <= {mRx[WORD_W-2:0], sensMiso};
            mBits    <= mBits + 1'b1;
            mState   <= M_HIGH;
          end
        end
        M_HIGH: begin
          if (halfDone) begin
            if (mBits == BITS_ALL) begin
              sensCsN <= 1'b1;
              gapCnt  <= '0;
              mState  <= M_GAP;
            end else begin
              sensSclk <= 1'b0;
              mShift   <= {mShift[WORD_W-2:0], 1'b0};
              mState   <= M_LOW;
            end
          end
        end
        M_GAP: begin
          gapCnt <= gapCnt + 1'b1;
          if (gapCnt == GAP_LAST) begin
            masterDone <= 1'b1;
            mState     <= M_IDLE;
          end
        end
        default: mState <= M_IDLE;
      endcase
    end
  end

  // ---------------- staged response and overrun counter ----------------
  logic [WORD_W-1:0] localResp;
  assign localResp = (!cmdIsWrite && cmdAddr == '0) ?
                     {{(WORD_W-BYTE_W){1'b0}}, page} : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 staged <= '0;
    else if (strb.stageMaster) staged <= mRx;
    else if (strb.stageLocal)  staged <= localResp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      overrunCount <= '0;
    else if (strb.incOverrun && overrunCount != '1)
      overrunCount <= overrunCount + 1'b1;
  end

  // ---------------- assertions ----------------
  // R2
  start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.startMaster |-> masterIdle);

  // R8
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    sensCsN |-> sensSclk);

  // R8
  cs_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sensCsN != $past(sensCsN)) |-> ($past(sensSclk) && sensSclk));

  // R7
  overrun_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incOverrun && overrunCount != '1) |=>
      (overrunCount == $past(overrunCount) + OVR_W'(1)));

  // R7
  overrun_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.incOverrun |=> $stable(overrunCount));

  // R10
  capture_framed_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWordValid |-> !$past(csS));

endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl
  import spi_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWordValid,
  input  logic              cmdIsWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [BYTE_W-1:0] cmdData,
  input  logic [BYTE_W-1:0] page,
  input  logic              masterDone,
  output bridgeStrobes_t    strb,
  output logic              busy
);

  ctrlState_t state, stateNext;
  logic isPageWrite;
  logic forward;

  assign isPageWrite = cmdIsWrite && (cmdAddr == '0);
  assign forward     = isPageWrite ? (cmdData < LOCAL_PAGE_MIN)
                                   : (page < LOCAL_PAGE_MIN);
  assign busy        = (state != C_IDLE);

  always_comb begin
    stateNext = state;
    strb      = '0;
    strb.incOverrun = hostWordValid && busy;
    unique case (state)
      C_IDLE: begin
        if (hostWordValid) begin
          strb.latchCmd = 1'b1;
          stateNext     = C_DISPATCH;
        end
      end
      C_DISPATCH: begin
        strb.setPage = isPageWrite;
        if (forward) begin
          strb.startMaster = 1'b1;
          stateNext        = C_XFER1;
        end else begin
          strb.stageLocal = 1'b1;
          stateNext       = C_IDLE;
        end
      end
      C_XFER1: begin
        if (masterDone) begin
          if (cmdIsWrite) begin
            strb.stageMaster = 1'b1;
            stateNext        = C_IDLE;
          end else begin
            strb.startMaster = 1'b1;
            strb.sendDummy   = 1'b1;
            stateNext        = C_XFER2;
          end
        end
      end
      C_XFER2: begin
        if (masterDone) begin
          strb.stageMaster = 1'b1;
          stateNext        = C_IDLE;
        end
      end
      default: stateNext = C_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= C_IDLE;
    else       state <= stateNext;
  end

  // R7
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostWordValid) |=> (state != C_DISPATCH));

  // R4
  write_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == C_XFER1 && masterDone && cmdIsWrite) |=> (state == C_IDLE));

  // R5
  local_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == C_DISPATCH && !isPageWrite && page >= LOCAL_PAGE_MIN)
      |=> (state == C_IDLE));

endmodule

// File: rtl/spi_bridge.sv
module spi_bridge
  import spi_bridge_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int CS_GAP  = 4,
  parameter int OVR_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostSclk,
  input  logic             hostCsN,
  input  logic             hostMosi,
  output logic             hostMiso,
  output logic             sensSclk,
  output logic             sensCsN,
  output logic             sensMosi,
  input  logic             sensMiso,
  output logic             busy,
  output logic [OVR_W-1:0] overrunCount
);

  bridgeStrobes_t    strb;
  logic              hostWordValid;
  logic              cmdIsWrite;
  logic [ADDR_W-1:0] cmdAddr;
  logic [BYTE_W-1:0] cmdData;
  logic [BYTE_W-1:0] page;
  logic              masterDone;
  logic              masterIdle;

  spi_bridge_datapath #(
    .CLK_DIV (CLK_DIV),
    .CS_GAP  (CS_GAP),
    .OVR_W   (OVR_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .hostSclk      (hostSclk),
    .hostCsN       (hostCsN),
    .hostMosi      (hostMosi),
    .hostMiso      (hostMiso),
    .sensSclk      (sensSclk),
    .sensCsN       (sensCsN),
    .sensMosi      (sensMosi),
    .sensMiso      (sensMiso),
    .strb          (strb),
    .hostWordValid (hostWordValid),
    .cmdIsWrite    (cmdIsWrite),
    .cmdAddr       (cmdAddr),
    .cmdData       (cmdData),
    .page          (page),
    .masterDone    (masterDone),
    .masterIdle    (masterIdle),
    .overrunCount  (overrunCount)
  );

  spi_bridge_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .hostWordValid (hostWordValid),
    .cmdIsWrite    (cmdIsWrite),
    .cmdAddr       (cmdAddr),
    .cmdData       (cmdData),
    .page          (page),
    .masterDone    (masterDone),
    .strb          (strb),
    .busy          (busy)
  );

  // R9
  master_done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    masterDone |-> (masterIdle && sensCsN));

endmodule

// File: tb/spi_bridge_tb.sv
module spi_bridge_tb;

  localparam int CLK_DIV = 4;
  localparam int CS_GAP  = 4;
  localparam int OVR_W   = 8;
  localparam int H       = 6;   // host half period in clk cycles

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSclk = 1'b1, hostCsN = 1'b1, hostMosi = 1'b0;
  logic hostMiso;
  logic sensSclk, sensCsN, sensMosi;
  logic sensMiso = 1'b0;
  logic busy;
  logic [OVR_W-1:0] overrunCount;

  always #4 clk = ~clk;   // 125 MHz

  spi_bridge #(.CLK_DIV(CLK_DIV), .CS_GAP(CS_GAP), .OVR_W(OVR_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .hostSclk(hostSclk), .hostCsN(hostCsN), .hostMosi(hostMosi), .hostMiso(hostMiso),
    .sensSclk(sensSclk), .sensCsN(sensCsN), .sensMosi(sensMosi), .sensMiso(sensMiso),
    .busy(busy), .overrunCount(overrunCount)
  );

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- sensor model ----------------
  logic [15:0] sResp = 16'h0000;
  logic [15:0] sTx   = 16'h0000;
  logic [15:0] sRx   = 16'h0000;
  logic [7:0]  sPage = 8'h00;
  int          sBits = 0;
  int          sCount = 0;
  logic [15:0] sLog [0:63];
  int          modeViol = 0;

  always @(negedge sensCsN) begin
    if (sensSclk !== 1'b1) modeViol++;
    sTx = sResp; sBits = 0; sensMiso = sResp[15];
  end
  always @(posedge sensSclk) if (!sensCsN) begin
    sRx = {sRx[14:0], sensMosi}; sBits++;
  end
  always @(negedge sensSclk) if (!sensCsN && sBits < 16) sensMiso = sTx[15 - sBits];
  always @(posedge sensCsN) if (rstN) begin
    if (sensSclk !== 1'b1) modeViol++;
    if (sBits == 16) begin
      sLog[sCount % 64] = sRx;
      sCount++;
      if (sRx[15]) begin
        if (sRx[14:8] == 7'd0) sPage = sRx[7:0];
        sResp = ~sRx;
      end else begin
        sResp = {sPage, 1'b0, sRx[14:8]};
      end
    end
  end

  // ---------------- sensor clock timing monitor ----------------
  int  runLen = 0, gapLen = 0, timeViol = 0, txnSeen = 0;
  logic prevCs = 1'b1, prevSclk = 1'b1;
  always @(posedge clk) if (rstN) begin
    if (!sensCsN && prevCs) begin
      if (txnSeen > 0 && gapLen < CS_GAP) timeViol++;
      runLen = 1;
    end else if (!sensCsN) begin
      if (sensSclk == prevSclk) runLen++;
      else begin
        if (runLen != CLK_DIV) timeViol++;
        runLen = 1;
      end
    end else if (!prevCs) begin
      if (runLen != CLK_DIV) timeViol++;
      gapLen = 1; txnSeen++;
    end else gapLen++;
    prevCs = sensCsN; prevSclk = sensSclk;
  end

  // ---------------- host driver ----------------
  task automatic hostXfer(input logic [15:0] w, input int nBits, output logic [15:0] r);
    r = '0;
    @(negedge clk) hostCsN = 1'b0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      hostSclk = 1'b0; hostMosi = w[15-i];
      repeat (H) @(negedge clk);
      r[15-i] = hostMiso;
      hostSclk = 1'b1;
      repeat (H) @(negedge clk);
    end
    hostCsN = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk(busy, 0, "R11 busy after reset");
    chk(overrunCount, 0, "R11 overrun after reset");
    chk(sensCsN, 1, "R11 sensor select idle");
    chk(sensSclk, 1, "R11 sensor clock idle");
  endtask

  task automatic t_fwdRead();
    logic [15:0] r; int c0 = sCount;
    hostXfer(16'h1200, 16, r);
    chk(r, 16'h0000, "R11 staged word after reset");
    chk(busy, 1, "R7 busy after forwarded read capture");
    waitIdle();
    chk(sCount - c0, 2, "R2 read transaction count");
    chk(sLog[c0 % 64], 16'h1200, "R1 request word verbatim");
    chk(sLog[(c0+1) % 64], 16'h0000, "R2 second word zero");
  endtask

  task automatic t_fwdWrite();
    logic [15:0] r, pre; int c0 = sCount;
    pre = sResp;
    hostXfer(16'h9234, 16, r);
    chk(r, 16'h0012, "R3 read data on next word");
    waitIdle();
    chk(sCount - c0, 1, "R4 write transaction count");
    chk(sLog[c0 % 64], 16'h9234, "R1 write word verbatim");
    hostXfer(16'h80FF, 16, r);
    chk(r, pre, "R4 write response staged");
    waitIdle();
    chk(sCount - c0, 1, "R6 page 255 write not forwarded");
  endtask

  task automatic t_localPages();
    logic [15:0] r; int c0 = sCount;
    hostXfer(16'h1200, 16, r);
    chk(r, 16'h0000, "R5 local page write stages zero");
    waitIdle();
    hostXfer(16'h0000, 16, r);
    chk(r, 16'h0000, "R5 local read of non-page address");
    waitIdle();
    hostXfer(16'h80FD, 16, r);
    chk(r, 16'h00FF, "R5 local page read returns 255");
    waitIdle();
    hostXfer(16'h0000, 16, r);
    waitIdle();
    hostXfer(16'h1234, 16, r);
    chk(r, 16'h00FD, "R5 local page read returns 253");
    waitIdle();
    hostXfer(16'h80FE, 16, r);
    waitIdle();
    hostXfer(16'h0000, 16, r);
    waitIdle();
    hostXfer(16'h0000, 16, r);
    chk(r, 16'h00FE, "R5 local page read returns 254");
    waitIdle();
    chk(sCount - c0, 0, "R5 no sensor traffic on local pages");
  endtask

  task automatic t_backToSensor();
    logic [15:0] r, pre; int c0 = sCount;
    pre = sResp;
    hostXfer(16'h80FC, 16, r);
    waitIdle();
    chk(sCount - c0, 1, "R6 page 252 write forwarded");
    chk(sLog[c0 % 64], 16'h80FC, "R6 page write word");
    hostXfer(16'h0500, 16, r);
    chk(r, pre, "R4 page write response staged");
    waitIdle();
    chk(sCount - c0, 3, "R6 read forwarded on page 252");
    hostXfer(16'h8000, 16, r);
    chk(r, 16'hFC05, "R3 sensor page seen in read data");
    waitIdle();
    chk(sCount - c0, 4, "R6 page 0 write forwarded");
  endtask

  task automatic t_overrun();
    logic [15:0] r; int c0 = sCount;
    logic [OVR_W-1:0] ov0 = overrunCount;
    hostXfer(16'h0700, 16, r);
    chk(busy, 1, "R7 busy before second word");
    hostXfer(16'h8A55, 16, r);
    chk(overrunCount, ov0 + 1'b1, "R7 overrun counted");
    waitIdle();
    chk(sCount - c0, 2, "R7 dropped word not forwarded");
    chk(sLog[(c0+1) % 64], 16'h0000, "R7 read sequence intact");
    hostXfer(16'h0000, 16, r);
    chk(r, 16'h0007, "R7 read data survives overrun");
    waitIdle();
  endtask

  task automatic t_partial();
    logic [15:0] r; int c0 = sCount;
    logic [OVR_W-1:0] ov0 = overrunCount;
    hostXfer(16'h0900, 16, r);
    waitIdle();
    c0 = sCount;
    hostXfer(16'h8012, 8, r);
    chk(busy, 0, "R10 no busy for partial word");
    waitIdle();
    chk(sCount - c0, 0, "R10 partial word not forwarded");
    chk(overrunCount, ov0, "R10 overrun unchanged");
    hostXfer(16'h0000, 16, r);
    chk(r, 16'h0009, "R10 staged word unchanged");
    waitIdle();
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_fwdRead();
    t_fwdWrite();
    t_localPages();
    t_backToSensor();
    t_overrun();
    t_partial();
    chk(modeViol, 0, "R8 select edges with clock high");
    chk(timeViol, 0, "R9 sensor clock phases and gap");
    done = 1;
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

endmodule